// File: doc/BRIEF.md
# DMA Channel Trigger Front End and Preemptive Scheduler

This block sits in front of a DMA transfer engine and decides which of eight channels moves the next data unit. Every channel owns a small configuration: a 2-bit source selector that routes one of three hardware request lines to the channel, or none of them. It also has an enable bit and a mode bit that chooses between single and successive transfers. Rising edges on the selected hardware line, and pulses on the channel's software trigger, set a sticky pending flag. The flag is set only while the channel is enabled.

A fixed-priority scheduler turns pending flags into grants. Channel 0 ranks first and channel 7 last. A single-mode channel moves one unit per request. A successive-mode channel keeps moving units until its 16-bit count, loaded through a small register port and reduced on every unit completion, reaches zero. While such a burst runs, a lower-priority request waits for the whole burst. A higher-priority request takes over at the next unit boundary, and the interrupted channel is parked. It resumes with whatever count it had left once nothing of higher rank is waiting. The engine reports the end of each unit with `unit_done`. The scheduler answers with the chosen channel number and a one-cycle `unit_start` strobe.

Top module: `dma_trig_arbiter`

## Requirements
- R1: After reset every channel has source code 0, enable 0 and successive mode 0, all counts read 0, and no grant is active. Hardware request edges then cause no grant.
- R2: Source code k (1, 2 or 3) routes hardware line k-1 of that channel, at flat bit index ch*3+k-1 of `hw_req`. The channel's other lines have no effect. Code 0 routes no line.
- R3: Only a rising edge of the routed line sets the pending flag. A line held high after its request was granted produces no further grant.
- R4: A software trigger sets the pending flag of an enabled channel whatever its source code, including code 0.
- R5: While a channel's enable bit is 0, neither hardware edges nor software triggers set its pending flag, and nothing is remembered once it is enabled later.
- R6: When several channels are eligible at a decision point, the one with the lowest index is granted.
- R7: In single mode a grant lasts exactly one data unit. At its `unit_done` the next eligible channel of any priority is granted, or the scheduler goes idle.
- R8: In successive mode, a lower-priority request is not granted until the active channel's count reaches zero. The channel keeps the grant and gets a new `unit_start` after every unit until then.
- R9: A higher-priority request arriving during a successive burst takes the grant only after the current unit's `unit_done`, never in the middle of a unit.
- R10: A preempted successive channel resumes after the higher-priority transfer ends, continuing from its remaining count rather than reloading.
- R11: Each `unit_done` reduces the active channel's count by one, saturating at 0. The count of any channel reads back on `cnt_rd_data`.
- R12: `unit_start` pulses for one cycle, in the cycle after a decision, together with the new `grant_ch`. `grant_valid` and `grant_ch` stay steady until the next `unit_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req | input | 24 | Hardware request lines, three per channel |
| sw_trig | input | 8 | Software trigger, one per channel |
| cfg_wr | input | 1 | Write strobe for channel configuration |
| cfg_ch | input | 3 | Channel addressed by a configuration write |
| cfg_src | input | 2 | Source code to store (0 = no hardware line) |
| cfg_en | input | 1 | Enable bit to store |
| cfg_succ | input | 1 | Mode bit to store (1 = successive) |
| cnt_wr | input | 1 | Write strobe for a channel count |
| cnt_ch | input | 3 | Channel addressed by a count write |
| cnt_data | input | 16 | Count value to load |
| cnt_rd_ch | input | 3 | Channel whose count is read back |
| cnt_rd_data | output | 16 | Current count of channel `cnt_rd_ch` |
| unit_done | input | 1 | Transfer engine finished the current unit |
| grant_valid | output | 1 | A channel holds the grant |
| grant_ch | output | 3 | Channel holding the grant |
| unit_start | output | 1 | One-cycle strobe starting a unit for `grant_ch` |

## Verification
The bench builds the block with its default parameters: eight channels, three request lines per channel and 16-bit counts. With eight channels it can drive a contest between the top and bottom ranks as well as between neighbours in the middle. Three lines per channel let it show that only the routed line counts. Small count loads of three and four units keep bursts short, yet they are still long enough to place a high-priority request in the middle of a burst and a low-priority one ahead of a burst's end. The remaining count is then read through the register port before and after the takeover.

// File: rtl/dta_pkg.sv
// Package dta_pkg
// Shared constants for the DMA trigger front end and scheduler.
// Assumes: the source code width is fixed at two bits (code 0 = no line).
package dta_pkg;
    localparam int SRC_CODE_W = 2;
endpackage

// File: rtl/dta_cfg_regs.sv
// Module dta_cfg_regs
// Holds per-channel source code, enable bit and mode bit, written one
// channel at a time. Assumes: writes are single-cycle strobes.
module dta_cfg_regs #(
    parameter int NCH  = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr,
    input  logic [CH_W-1:0]                       wr_ch,
    input  logic [dta_pkg::SRC_CODE_W-1:0]        wr_src,
    input  logic                                  wr_en,
    input  logic                                  wr_succ,
    output logic [NCH-1:0][dta_pkg::SRC_CODE_W-1:0] src_q,
    output logic [NCH-1:0]                        en_q,
    output logic [NCH-1:0]                        succ_q
);
    // Store configuration; reset puts every channel in the no-line, disabled state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            en_q   <= '0;
            succ_q <= '0;
        end else if (wr) begin
            src_q[wr_ch]  <= wr_src;
            en_q[wr_ch]   <= wr_en;
            succ_q[wr_ch] <= wr_succ;
        end
    end
endmodule

// File: rtl/dta_req_latch.sv
// Module dta_req_latch
// Detects rising edges on the routed hardware line of each channel, merges
// software triggers and keeps a sticky pending flag per channel.
// Assumes: hw lines are synchronous to clk; clr is one-hot or zero.
module dta_req_latch #(
    parameter int NCH  = 8,
    parameter int NSRC = 3
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NCH-1:0][NSRC-1:0]                hw,
    input  logic [NCH-1:0][dta_pkg::SRC_CODE_W-1:0] src,
    input  logic [NCH-1:0]                          en,
    input  logic [NCH-1:0]                          sw,
    input  logic [NCH-1:0]                          clr,
    output logic [NCH-1:0]                          pend
);
    logic [NCH-1:0][NSRC-1:0] hw_prev;
    logic [NCH-1:0]           set;

    // Remember last line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hw_prev <= '0;
        else        hw_prev <= hw;
    end

    // Per channel: pick the routed line's edge and combine with software trigger.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [NSRC-1:0] rise;
        logic            hw_hit;
        assign rise = hw[c] & ~hw_prev[c];
        always_comb begin
            hw_hit = 1'b0;
            for (int k = 1; k <= NSRC; k++)
                if (int'(src[c]) == k) hw_hit = rise[k-1];
        end
        assign set[c] = en[c] & (hw_hit | sw[c]);
    end

    // Sticky pending flags: cleared on grant, a fresh request wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | set;
    end

    // R5: a disabled channel without a request stays without one.
    a_r5_disabled_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(~en & ~pend)) == '0));
endmodule

// File: rtl/dta_cnt_bank.sv
// Module dta_cnt_bank
// Per-channel unit counters: loaded through a write port, reduced by one on
// each finished unit of the active channel, saturating at zero.
// Assumes: a write to the channel being reduced in the same cycle wins.
module dta_cnt_bank #(
    parameter int NCH   = 8,
    parameter int CNT_W = 16,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             dec,
    input  logic [CH_W-1:0]  dec_ch,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [CNT_W-1:0] rd_data,
    output logic             last
);
    logic [NCH-1:0][CNT_W-1:0] cnt;

    // Update counters: write has priority over the reduction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            if (dec && cnt[dec_ch] != '0) cnt[dec_ch] <= cnt[dec_ch] - CNT_W'(1);
            if (wr) cnt[wr_ch] <= wr_data;
        end
    end

    // Read back and flag that the active channel finishes with this unit.
    assign rd_data = cnt[rd_ch];
    assign last    = (cnt[dec_ch] <= CNT_W'(1));

    // R11: an unobstructed reduction lowers the count by exactly one.
    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !(wr && wr_ch == dec_ch) && cnt[dec_ch] != '0)
        |=> (cnt[$past(dec_ch)] == $past(cnt[dec_ch]) - CNT_W'(1)));
endmodule

// File: rtl/dta_sched.sv
// Module dta_sched
// Fixed-priority scheduler (index 0 first). Decides when idle or at a unit
// boundary; parks successive channels that still have units left so a
// lower-priority channel cannot pass them while higher ones can.
// Assumes: unit_done is a single-cycle pulse and arrives only while granted.
module dta_sched #(
    parameter int NCH  = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  pend,
    input  logic [NCH-1:0]  succ,
    input  logic            unit_done,
    input  logic            last,
    output logic [NCH-1:0]  clr,
    output logic            busy,
    output logic [CH_W-1:0] act_ch,
    output logic            unit_start
);
    logic [NCH-1:0]  parked, parked_nx, cand, act_oh, win_oh;
    logic [CH_W-1:0] win;
    logic            any, decide, cont;

    // Work out continuation, the eligible set and the winner.
    always_comb begin
        act_oh    = NCH'(1) << act_ch;
        cont      = busy && unit_done && succ[act_ch] && !last;
        parked_nx = parked | (cont ? act_oh : '0);
        cand      = pend | parked_nx;
        decide    = !busy || unit_done;
        win       = '0;
        any       = 1'b0;
        for (int i = NCH - 1; i >= 0; i--)
            if (cand[i]) begin
                win = CH_W'(i);
                any = 1'b1;
            end
        win_oh = NCH'(1) << win;
        clr    = (decide && any && !parked_nx[win]) ? win_oh : '0;
    end

    // Grant state: new channel or resume at a decision point, idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            act_ch     <= '0;
            unit_start <= 1'b0;
            parked     <= '0;
        end else if (decide) begin
            busy       <= any;
            unit_start <= any;
            if (any) act_ch <= win;
            parked     <= any ? (parked_nx & ~win_oh) : parked_nx;
        end else begin
            unit_start <= 1'b0;
        end
    end

    // R12: a strobe only comes with a live grant.
    a_r12_start_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
        unit_start |-> busy);
    // R9: grant stays put in the middle of a unit.
    a_r9_hold_until_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !unit_done) |=> (busy && act_ch == $past(act_ch) && !unit_start));
    // R8: a continuing burst is never passed by a lower-priority channel.
    a_r8_no_lower_midburst: assert property (@(posedge clk) disable iff (!rst_n)
        cont |=> (busy && act_ch <= $past(act_ch)));
    // R6: at most one pending flag is consumed per decision.
    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));
endmodule

// File: rtl/dma_trig_arbiter.sv
// Module dma_trig_arbiter
// Top: configuration registers, request latching, unit counters and the
// preemptive fixed-priority scheduler.
// Assumes: all inputs are synchronous to clk; the transfer engine answers
// each unit_start with exactly one unit_done.
module dma_trig_arbiter #(
    parameter int NCH   = 8,
    parameter int NSRC  = 3,
    parameter int CNT_W = 16,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH*NSRC-1:0]    hw_req,
    input  logic [NCH-1:0]         sw_trig,
    input  logic                   cfg_wr,
    input  logic [CH_W-1:0]        cfg_ch,
    input  logic [1:0]             cfg_src,
    input  logic                   cfg_en,
    input  logic                   cfg_succ,
    input  logic                   cnt_wr,
    input  logic [CH_W-1:0]        cnt_ch,
    input  logic [CNT_W-1:0]       cnt_data,
    input  logic [CH_W-1:0]        cnt_rd_ch,
    output logic [CNT_W-1:0]       cnt_rd_data,
    input  logic                   unit_done,
    output logic                   grant_valid,
    output logic [CH_W-1:0]        grant_ch,
    output logic                   unit_start
);
    logic [NCH-1:0][dta_pkg::SRC_CODE_W-1:0] src_q;
    logic [NCH-1:0]           en_q, succ_q, pend, clr;
    logic [NCH-1:0][NSRC-1:0] hw_arr;
    logic                     last, busy;
    logic [CH_W-1:0]          act_ch;

    assign hw_arr = hw_req;

    dta_cfg_regs #(.NCH(NCH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_ch(cfg_ch),
        .wr_src(cfg_src), .wr_en(cfg_en), .wr_succ(cfg_succ),
        .src_q(src_q), .en_q(en_q), .succ_q(succ_q));

    dta_req_latch #(.NCH(NCH), .NSRC(NSRC)) u_req (
        .clk(clk), .rst_n(rst_n), .hw(hw_arr), .src(src_q), .en(en_q),
        .sw(sw_trig), .clr(clr), .pend(pend));

    dta_cnt_bank #(.NCH(NCH), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr(cnt_wr), .wr_ch(cnt_ch),
        .wr_data(cnt_data), .dec(unit_done && busy), .dec_ch(act_ch),
        .rd_ch(cnt_rd_ch), .rd_data(cnt_rd_data), .last(last));

    dta_sched #(.NCH(NCH)) u_sched (
        .clk(clk), .rst_n(rst_n), .pend(pend), .succ(succ_q),
        .unit_done(unit_done), .last(last), .clr(clr), .busy(busy),
        .act_ch(act_ch), .unit_start(unit_start));

    assign grant_valid = busy;
    assign grant_ch    = act_ch;
endmodule

// File: tb/sim_dma_trig_arbiter.sv
module sim_dma_trig_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] hw_req = '0;
    logic [7:0]  sw_trig = '0;
    logic        cfg_wr = 1'b0, cfg_en = 1'b0, cfg_succ = 1'b0;
    logic [2:0]  cfg_ch = '0, cnt_ch = '0, cnt_rd_ch = '0;
    logic [1:0]  cfg_src = '0;
    logic        cnt_wr = 1'b0, unit_done = 1'b0;
    logic [15:0] cnt_data = '0, cnt_rd_data;
    logic        grant_valid, unit_start;
    logic [2:0]  grant_ch;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_trig_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_trig(sw_trig),
        .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_src(cfg_src), .cfg_en(cfg_en),
        .cfg_succ(cfg_succ), .cnt_wr(cnt_wr), .cnt_ch(cnt_ch),
        .cnt_data(cnt_data), .cnt_rd_ch(cnt_rd_ch), .cnt_rd_data(cnt_rd_data),
        .unit_done(unit_done), .grant_valid(grant_valid), .grant_ch(grant_ch),
        .unit_start(unit_start));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int ch, input int src, input bit en, input bit succ);
        cfg_wr = 1; cfg_ch = 3'(ch); cfg_src = 2'(src); cfg_en = en; cfg_succ = succ;
        tick(); cfg_wr = 0;
    endtask

    task automatic load_cnt(input int ch, input int val);
        cnt_wr = 1; cnt_ch = 3'(ch); cnt_data = 16'(val);
        tick(); cnt_wr = 0;
    endtask

    function automatic int count_of(input int ch);
        cnt_rd_ch = 3'(ch);
        return 0;
    endfunction

    task automatic read_cnt(input int ch, output int v);
        cnt_rd_ch = 3'(ch); #1 v = int'(cnt_rd_data);
    endtask

    // Software pulse; on return the grant decision (if any) is visible.
    task automatic pulse_sw(input logic [7:0] m);
        sw_trig = m; tick(); sw_trig = '0; tick();
    endtask

    task automatic finish_unit();
        unit_done = 1; tick(); unit_done = 0;
    endtask

    task automatic expect_grant(input string tag, input int ch);
        chk({tag, " unit_start"}, int'(unit_start), 1);
        chk({tag, " grant_valid"}, int'(grant_valid), 1);
        chk({tag, " grant_ch"}, int'(grant_ch), ch);
    endtask

    task automatic expect_idle(input string tag);
        chk({tag, " grant_valid"}, int'(grant_valid), 0);
        chk({tag, " unit_start"}, int'(unit_start), 0);
    endtask

    task automatic t_reset();
        int v;
        expect_idle("R1 reset");
        read_cnt(3, v); chk("R1 count reset", v, 0);
        hw_req[3*3 +: 3] = 3'b111; tick(3);
        expect_idle("R1 source code 0 after reset");
        hw_req = '0; tick();
    endtask

    task automatic t_soft();
        set_cfg(2, 0, 1, 0);
        pulse_sw(8'h04);
        expect_grant("R4 sw with code 0", 2);
        tick();
        chk("R12 strobe one cycle", int'(unit_start), 0);
        chk("R12 grant held", int'(grant_ch), 2);
        finish_unit();
        expect_idle("R7 single ends after one unit");
    endtask

    task automatic t_disable();
        set_cfg(5, 1, 0, 0);
        pulse_sw(8'h20); tick();
        expect_idle("R5 sw while disabled");
        hw_req[5*3] = 1; tick(3); hw_req[5*3] = 0;
        expect_idle("R5 hw while disabled");
        set_cfg(5, 1, 1, 0); tick(3);
        expect_idle("R5 nothing remembered");
    endtask

    task automatic t_select();
        set_cfg(4, 2, 1, 0);
        hw_req[4*3 + 0] = 1; hw_req[4*3 + 2] = 1; tick(3);
        expect_idle("R2 unrouted lines ignored");
        hw_req[4*3 + 1] = 1; tick(2);
        expect_grant("R2 routed line", 4);
        finish_unit(); tick(3);
        expect_idle("R3 held level no retrigger");
        hw_req[4*3 + 1] = 0; tick();
        hw_req[4*3 + 1] = 1; tick(2);
        expect_grant("R3 new edge", 4);
        finish_unit();
        hw_req = '0; tick();
    endtask

    task automatic t_priority();
        set_cfg(1, 0, 1, 0);
        set_cfg(6, 0, 1, 0);
        pulse_sw(8'h42);
        expect_grant("R6 lowest index first", 1);
        finish_unit();
        expect_grant("R7 next after one unit", 6);
        finish_unit();
        expect_idle("R7 idle when none left");
    endtask

    task automatic t_low_waits();
        int v;
        set_cfg(3, 0, 1, 1);
        load_cnt(3, 3);
        pulse_sw(8'h08);
        expect_grant("R8 burst start", 3);
        read_cnt(3, v); chk("R11 loaded count", v, 3);
        sw_trig = 8'h40; tick(); sw_trig = '0; tick(2);
        chk("R8 low waits mid-unit", int'(grant_ch), 3);
        finish_unit();
        expect_grant("R8 burst continues", 3);
        read_cnt(3, v); chk("R11 count after unit", v, 2);
        finish_unit();
        expect_grant("R8 burst continues again", 3);
        finish_unit();
        read_cnt(3, v); chk("R11 count reaches zero", v, 0);
        expect_grant("R8 low after burst end", 6);
        finish_unit();
        expect_idle("R8 all done");
    endtask

    task automatic t_preempt();
        int v;
        set_cfg(5, 0, 1, 1);
        load_cnt(5, 4);
        pulse_sw(8'h20);
        expect_grant("R9 burst start", 5);
        finish_unit();
        expect_grant("R9 burst unit two", 5);
        sw_trig = 8'h02; tick(); sw_trig = '0; tick(2);
        chk("R9 no preempt mid-unit", int'(grant_ch), 5);
        chk("R9 no strobe mid-unit", int'(unit_start), 0);
        finish_unit();
        expect_grant("R9 preempt at boundary", 1);
        read_cnt(5, v); chk("R10 parked count kept", v, 2);
        finish_unit();
        expect_grant("R10 resume", 5);
        read_cnt(5, v); chk("R10 count not reloaded", v, 2);
        finish_unit();
        expect_grant("R10 resumed unit two", 5);
        finish_unit();
        expect_idle("R10 burst ends on remaining count");
        read_cnt(5, v); chk("R10 final count", v, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        t_reset();
        t_soft();
        t_disable();
        t_select();
        t_priority();
        t_low_waits();
        t_preempt();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule